// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C-compatible target that lets a bus controller read and write a small file of 8-bit registers kept outside the block. It samples the SCL and SDA wires with the system clock through two-flop synchronizers. From those samples it detects START, repeated START and STOP conditions, and it responds only to the fixed 7-bit device address 0x60. It drives SDA through an open-drain style output enable: asserting the enable pulls the wire low.

A write transaction carries three kinds of byte in turn. The first is the address byte with direction bit 0. The second loads the register pointer. Every byte after that is written to the register the pointer names, and the pointer then steps on. A read has no register byte of its own. The controller first performs a write phase that loads the pointer, then issues a repeated START with direction bit 1. The target returns bytes from the pointer onward until the controller declines one.

A separate active-low pin, `nrst_n`, silences the target. While it is low, the target never pulls SDA, so it sends neither acknowledges nor read data.

Top module: `i2c_reg_target`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `sda_oe` and `reg_wr_en` are 0.
- R2: After an address byte whose upper seven bits equal 0x60, sent MSB first, the target pulls SDA low through the high phase of the ninth SCL pulse, for either value of bit 0 (0 = write, 1 = read).
- R3: An address byte with any other upper seven bits gets no acknowledge. The target then drives nothing and writes nothing until the next START.
- R4: In a write, the byte after the address loads the pointer. Each later byte is written to the pointer's register, acknowledged, and followed by a pointer increment that wraps from 0xFF to 0x00.
- R5: After a repeated START with direction bit 1, the target sends the byte at the pointer MSB first, then increments the pointer. Each acknowledge from the controller brings the next byte.
- R6: When the controller leaves SDA high in the acknowledge slot after a read byte, the target stops driving and stays released until the next START or STOP.
- R7: While `nrst_n` is 0, `sda_oe` is 0. Acknowledges and read data are therefore absent. They return once `nrst_n` is 1 again.
- R8: A START or STOP in the middle of a byte abandons the transaction. The partial byte is never written.
- R9: `sda_oe` never rises while SCL is high, because the target updates it only after it detects a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| nrst_n | input | 1 | Active-low pin; 0 blocks all SDA driving |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_rd_addr | output | AW | Register pointer, used as the read address |
| reg_rd_data | input | 8 | Contents of the register at `reg_rd_addr` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_addr | output | AW | Register written on the strobe |
| reg_wr_data | output | 8 | Byte written on the strobe |

## Verification
The bench sends every address that differs from 0x60 by a single bit, in both directions. A design that compared too few bits would acknowledge one of them and corrupt a register. Writes and reads that start at 0xFE catch a pointer that saturates instead of wrapping, or that steps at the wrong time; such a design would return or overwrite the wrong register. A STOP or START issued halfway through a byte shows whether a design commits partial bytes. Clocking a further byte after the controller's NACK, and running whole transactions with `nrst_n` held low, shows whether the target still pulls SDA when it should be silent.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REG,
        ST_REG_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_e;

    // Bus events extracted from the synchronized lines.
    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= scl_in;
                    sda_q <= sda_in;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_in};
                    sda_q <= {sda_q[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_tgt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        // SDA edges while SCL holds high are bus conditions, not data.
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60,
    parameter int         AW       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              drive,
    output logic [AW-1:0]     ptr,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    tgt_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txb;
    logic              is_read;
    logic              mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            shreg   <= '0;
            txb     <= '0;
            is_read <= 1'b0;
            mack    <= 1'b0;
            drive   <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (evt.start) begin
                state <= ST_ADDR;
                cnt   <= '0;
                drive <= 1'b0;
            end else if (evt.stop) begin
                state <= ST_IDLE;
                cnt   <= '0;
                drive <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_REG, ST_WDATA: begin
                        if (evt.scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], evt.sda};
                            cnt   <= cnt + 1'b1;
                        end else if (evt.scl_fall && cnt == LAST_BIT) begin
                            if (state == ST_ADDR) begin
                                if (addr_hit(shreg, DEV_ADDR)) begin
                                    drive   <= 1'b1;
                                    is_read <= shreg[0];
                                    state   <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_IGNORE;
                                end
                            end else if (state == ST_REG) begin
                                ptr   <= shreg[AW-1:0];
                                drive <= 1'b1;
                                state <= ST_REG_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                                drive   <= 1'b1;
                                state   <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (is_read) begin
                                txb   <= rd_data;
                                drive <= ~rd_data[BYTE_W-1];
                                state <= ST_TX;
                            end else begin
                                drive <= 1'b0;
                                state <= ST_REG;
                            end
                        end
                    end
                    ST_REG_ACK, ST_WDATA_ACK: begin
                        if (evt.scl_fall) begin
                            drive <= 1'b0;
                            cnt   <= '0;
                            state <= ST_WDATA;
                        end
                    end
                    ST_TX: begin
                        if (evt.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (evt.scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                drive <= 1'b0;
                                ptr   <= ptr + 1'b1;
                                state <= ST_TX_ACK;
                            end else begin
                                txb   <= {txb[BYTE_W-2:0], 1'b0};
                                drive <= ~txb[BYTE_W-2];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (evt.scl_rise) begin
                            mack <= ~evt.sda;
                        end else if (evt.scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                txb   <= rd_data;
                                drive <= ~rd_data[BYTE_W-1];
                                state <= ST_TX;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                    default: begin
                        drive <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h60,
    parameter int         AW          = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nrst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [AW-1:0]     reg_rd_addr,
    input  logic [BYTE_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [AW-1:0]     reg_wr_addr,
    output logic [BYTE_W-1:0] reg_wr_data
);
    logic     scl_s;
    logic     sda_s;
    bus_evt_t evt;
    logic     drive;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .scl_s  (scl_s),
        .sda_s  (sda_s)
    );

    i2c_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_s (scl_s),
        .sda_s (sda_s),
        .evt   (evt)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (reg_rd_data),
        .drive   (drive),
        .ptr     (reg_rd_addr),
        .wr_en   (reg_wr_en),
        .wr_addr (reg_wr_addr),
        .wr_data (reg_wr_data)
    );

    // The silencing pin gates the wire directly, without waiting for a clock.
    assign sda_oe = drive & nrst_n;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          nrst_n,
    input logic          scl_in,
    input logic          sda_oe,
    input logic [AW-1:0] reg_rd_addr,
    input logic          reg_wr_en,
    input logic [AW-1:0] reg_wr_addr
);
    // R7: no pull-down while the silencing pin is low
    p_silent_pin_r7: assert property (@(posedge clk) disable iff (rst)
        !nrst_n |-> !sda_oe);

    // R9: output enable never rises during a steady SCL high phase
    p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        (scl_in && $past(scl_in) && nrst_n && $past(nrst_n)) |-> !$rose(sda_oe));

    // R4: one strobe per received byte
    p_wr_single_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R4: pointer has already stepped past the register being written
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |-> reg_rd_addr == AW'(reg_wr_addr + 1'b1));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .nrst_n      (nrst_n),
    .scl_in      (scl_in),
    .sda_oe      (sda_oe),
    .reg_rd_addr (reg_rd_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_addr (reg_wr_addr)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst;
    logic       nrst_n;
    logic       m_scl;
    logic       m_sda;
    logic       sda_oe;
    logic       sda_bus;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic [7:0] mem [256];
    logic [7:0] expv [256];
    int         errors = 0;
    int         checks = 0;
    int         oe_events = 0;
    int         r9_bad = 0;
    logic       oe_prev = 1'b0;
    logic       ack;
    logic [7:0] rb;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;
    assign rd_data = mem[rd_addr];

    i2c_reg_target u_i2c_reg_target (
        .clk         (clk),
        .rst         (rst),
        .nrst_n      (nrst_n),
        .scl_in      (m_scl),
        .sda_in      (sda_bus),
        .sda_oe      (sda_oe),
        .reg_rd_addr (rd_addr),
        .reg_rd_data (rd_data),
        .reg_wr_en   (wr_en),
        .reg_wr_addr (wr_addr),
        .reg_wr_data (wr_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always @(posedge clk) begin
        oe_prev <= sda_oe;
        if (sda_oe) oe_events <= oe_events + 1;
        if (!rst && m_scl && sda_oe && !oe_prev) r9_bad <= r9_bad + 1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start;
        m_sda = 1'b1; wq(1);
        m_scl = 1'b1; wq(1);
        m_sda = 1'b0; wq(1);
        m_scl = 1'b0; wq(1);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; wq(1);
        m_scl = 1'b1; wq(1);
        m_sda = 1'b1; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(1);
            m_scl = 1'b1; wq(2);
            m_scl = 1'b0; wq(1);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic got_ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq(1);
        m_scl = 1'b1; wq(1);
        got_ack = ~sda_bus; wq(1);
        m_scl = 1'b0; wq(1);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(1);
            m_scl = 1'b1; wq(1);
            b[i] = sda_bus; wq(1);
            m_scl = 1'b0; wq(1);
        end
        m_sda = ~give_ack; wq(1);
        m_scl = 1'b1; wq(2);
        m_scl = 1'b0; wq(1);
        m_sda = 1'b1;
    endtask

    task automatic write_regs(input logic [7:0] start_reg, input int n, input logic [7:0] seed);
        logic a;
        bus_start;
        send_byte(8'hC0, a); check(a, "R2 write address ack", a, 1);
        send_byte(start_reg, a); check(a, "R4 pointer byte ack", a, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] v;
            v = 8'(seed + k * 29);
            send_byte(v, a); check(a, "R4 data byte ack", a, 1);
            expv[8'(start_reg + k)] = v;
        end
        bus_stop;
        wq(2);
    endtask

    task automatic read_regs(input logic [7:0] start_reg, input int n);
        logic a;
        logic [7:0] v;
        bus_start;
        send_byte(8'hC0, a); check(a, "R2 address ack before read", a, 1);
        send_byte(start_reg, a); check(a, "R5 pointer byte ack", a, 1);
        bus_start;
        send_byte(8'hC1, a); check(a, "R2 read address ack", a, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            check(v == expv[8'(start_reg + k)], "R5 read byte", v, expv[8'(start_reg + k)]);
        end
        bus_stop;
        wq(2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; nrst_n = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
        for (int i = 0; i < 256; i++) expv[i] = 8'(i * 37 + 5);
        repeat (6) @(negedge clk);
        check(!sda_oe, "R1 sda_oe in reset", sda_oe, 0);
        check(!wr_en, "R1 wr_en in reset", wr_en, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!sda_oe && !wr_en, "R1 first cycle after reset", {sda_oe, wr_en}, 0);
        wq(2);

        // R4: multi-byte write, then wrap across 0xFF
        write_regs(8'h10, 3, 8'h3C);
        for (int k = 0; k < 3; k++)
            check(mem[8'h10 + k] == expv[8'h10 + k], "R4 written value", mem[8'h10 + k], expv[8'h10 + k]);
        write_regs(8'hFE, 3, 8'h81);
        check(mem[8'hFE] == expv[8'hFE], "R4 wrap 0xFE", mem[8'hFE], expv[8'hFE]);
        check(mem[8'hFF] == expv[8'hFF], "R4 wrap 0xFF", mem[8'hFF], expv[8'hFF]);
        check(mem[8'h00] == expv[8'h00], "R4 wrap 0x00", mem[8'h00], expv[8'h00]);

        // R5: reads, including across the wrap and untouched registers
        read_regs(8'h10, 3);
        read_regs(8'hFE, 3);
        read_regs(8'h55, 2);

        // R6: after the controller's NACK, another clocked byte sees nothing
        bus_start;
        send_byte(8'hC0, ack);
        send_byte(8'h20, ack);
        bus_start;
        send_byte(8'hC1, ack);
        recv_byte(1'b0, rb);
        check(rb == expv[8'h20], "R6 last byte before NACK", rb, expv[8'h20]);
        oe_events = 0;
        recv_byte(1'b0, rb);
        check(rb == 8'hFF, "R6 bus released after NACK", rb, 8'hFF);
        check(oe_events == 0, "R6 no drive after NACK", oe_events, 0);
        bus_stop;
        wq(2);

        // R3: one-bit neighbours of the device address, both directions
        for (int i = 0; i < 7; i++) begin
            for (int d = 0; d < 2; d++) begin
                logic [6:0] ad;
                ad = 7'h60 ^ 7'(1 << i);
                oe_events = 0;
                bus_start;
                send_byte({ad, d[0]}, ack);
                check(!ack, "R3 mismatched address not acked", ack, 0);
                send_byte(8'h20, ack);
                send_byte(8'h5A, ack);
                check(oe_events == 0, "R3 ignored until START", oe_events, 0);
                bus_stop;
                wq(2);
            end
        end
        check(mem[8'h20] == expv[8'h20], "R3 no write from mismatch", mem[8'h20], expv[8'h20]);

        // R8: STOP in the middle of a data byte, START in the middle of another
        bus_start;
        send_byte(8'hC0, ack);
        send_byte(8'h30, ack);
        send_bits(8'hF0, 4);
        bus_stop;
        wq(2);
        check(mem[8'h30] == expv[8'h30], "R8 partial byte after STOP", mem[8'h30], expv[8'h30]);
        bus_start;
        send_byte(8'hC0, ack);
        send_byte(8'h31, ack);
        send_bits(8'h0F, 5);
        bus_start;
        send_byte(8'hC0, ack);
        check(ack, "R8 fresh transaction after START abort", ack, 1);
        send_byte(8'h30, ack);
        send_byte(8'hA5, ack);
        bus_stop;
        wq(2);
        expv[8'h30] = 8'hA5;
        check(mem[8'h31] == expv[8'h31], "R8 aborted byte not written", mem[8'h31], expv[8'h31]);
        check(mem[8'h30] == 8'hA5, "R8 write after abort", mem[8'h30], 8'hA5);

        // R7: silenced pin
        nrst_n = 1'b0;
        wq(1);
        oe_events = 0;
        bus_start;
        send_byte(8'hC0, ack);
        check(!ack, "R7 no ack while silenced", ack, 0);
        send_byte(8'h10, ack);
        bus_start;
        send_byte(8'hC1, ack);
        recv_byte(1'b0, rb);
        check(rb == 8'hFF, "R7 no read data while silenced", rb, 8'hFF);
        bus_stop;
        check(oe_events == 0, "R7 sda_oe stayed low", oe_events, 0);
        wq(1);
        nrst_n = 1'b1;
        wq(2);
        read_regs(8'h10, 2);

        check(r9_bad == 0, "R9 sda_oe rose while SCL high", r9_bad, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule